// File: doc/BRIEF.md
# Bus Strobe Timing Generator

This block generates the two timing strobes that an 8-bit controller core puts on its external memory bus. The first is an active-high address latch pulse. The second is an active-low program read strobe. The block runs directly from the oscillator clock. It splits time into machine cycles of six states, and each state lasts `PH` oscillator clocks, so a cycle is twelve clocks at the default setting. The clocks of a cycle are numbered k = 0 to 6·PH−1, and state s phase p is clock k = (s−1)·PH + (p−1).

The core reports four things about each machine cycle:
- whether code is being fetched from external program memory;
- whether the cycle moves a byte to or from external data memory;
- whether the cycle reads a constant table from code space;
- whether software has turned the free-running latch pulses off.

The block samples these four flags on the clock edge that starts the cycle and holds them until the cycle ends. During external data cycles it thins out the strobes, and it applies the latch-off control only while code runs from internal memory.

Top module: `bus_strobe_gen`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high at a rising edge, the cycle position returns to k = 0 (state 1, phase 1), `addr_latch` is low, `prog_rd_n` is high, and any read pulse carried over from the previous cycle is dropped. The flags sampled on the last reset edge govern the first machine cycle after release.
- R2: `addr_latch` can only be high for a single clock, in the last phase of state 1 (k = PH−1) or of state 4 (k = 4·PH−1). With `ext_exec`=0, `latch_off`=0 and `xdata_cycle`=0, it pulses at both slots, which is two pulses per machine cycle, or one pulse every 6·PH/2 oscillator clocks.
- R3: In a machine cycle with `xdata_cycle`=1, the state-1 latch pulse is left out. The state-4 pulse is still emitted.
- R4: With `latch_off`=1 and `ext_exec`=0, a plain cycle gives no latch pulse. A cycle with `table_read_cycle`=1 gives both pulses. A cycle with `xdata_cycle`=1 gives only the state-4 pulse.
- R5: With `ext_exec`=1, `latch_off` has no effect on `addr_latch`.
- R6: In a cycle with `ext_exec`=1 and `xdata_cycle`=0, `prog_rd_n` is low for states 3 and 4 (k = 2·PH to 4·PH−1). It is also low from state 6 of that cycle through state 1 of the next cycle (k = 5·PH to 6·PH−1, then k = 0 to PH−1 of the next cycle).
- R7: In a cycle with `ext_exec`=1 and `xdata_cycle`=1, both read pulses that would start in that cycle are suppressed. The state-1 tail of a pulse that began in the previous cycle still appears.
- R8: In a cycle with `ext_exec`=0, `prog_rd_n` stays high, apart from the state-1 tail of a pulse that began in the previous cycle.
- R9: A change on any flag input after the cycle has started has no effect until the next cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, one tick per oscillator period |
| rst | input | 1 | Synchronous reset, active high |
| ext_exec | input | 1 | Code is being fetched from external program memory |
| xdata_cycle | input | 1 | This machine cycle accesses external data memory |
| table_read_cycle | input | 1 | This machine cycle reads a constant table from code space |
| latch_off | input | 1 | Control bit that turns off free-running latch pulses |
| addr_latch | output | 1 | Address latch strobe, active high |
| prog_rd_n | output | 1 | Program memory read strobe, active low |

## Verification
The tricky overlap is a data cycle with external execution, where three things fall in the same cycle. The tail of the read pulse carried from the previous cycle must still appear. The new read pulses must be dropped. The latch-off bit must be ignored while the state-1 latch pulse is still skipped. The bench provokes every ordered pair of the sixteen flag combinations back to back, so each carried tail meets every kind of following cycle. It also spends a long stretch changing the flags on every clock, which shows that only values present at a cycle start take effect. Every output is compared on every clock against a position-and-flag formula worked out independently in the bench.

// File: rtl/bstrobe_pkg.sv
package bstrobe_pkg;

  // states per machine cycle and the states that carry strobe activity
  localparam int unsigned NUM_STATES   = 6;
  localparam int unsigned ALE_STATE_A  = 1;
  localparam int unsigned ALE_STATE_B  = 4;
  localparam int unsigned RD_A_FIRST   = 3;
  localparam int unsigned RD_A_LAST    = 4;
  localparam int unsigned RD_B_STATE   = NUM_STATES;
  localparam int unsigned RD_TAIL_ST   = 1;

  typedef struct packed {
    logic ext_exec;
    logic xdata;
    logic table_rd;
    logic ale_off;
  } cyc_ctl_t;

  // clock index of the last phase of a state (states are 1-based)
  function automatic int unsigned last_phase_idx(input int unsigned st,
                                                 input int unsigned ph);
    return st * ph - 1;
  endfunction

  // true when idx lies within states first..last inclusive
  function automatic logic in_states(input int unsigned idx,
                                     input int unsigned first,
                                     input int unsigned last,
                                     input int unsigned ph);
    return (idx >= (first - 1) * ph) && (idx <= last * ph - 1);
  endfunction

endpackage

// File: rtl/mc_phase_counter.sv
module mc_phase_counter #(
  parameter int unsigned CYC_LEN = 12,
  localparam int unsigned CW = $clog2(CYC_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] idx_o,
  output logic          load_o
);

  localparam logic [CW-1:0] LAST = CW'(CYC_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  // the edge that enters clock 0 of a cycle: reset or wrap
  assign load_o  = rst | at_last;
  assign idx_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (at_last) cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/cycle_ctl_reg.sv
module cycle_ctl_reg
  import bstrobe_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load_i,
  input  cyc_ctl_t ctl_i,
  input  logic     rd_en_i,
  output cyc_ctl_t ctl_o,
  output logic     rd_tail_o
);

  cyc_ctl_t ctl_q;
  logic     tail_q;

  always_ff @(posedge clk) begin
    if (load_i) ctl_q <= ctl_i;
  end

  // a read pulse opened in state 6 spills into state 1 of the next cycle
  always_ff @(posedge clk) begin
    if (rst)         tail_q <= 1'b0;
    else if (load_i) tail_q <= rd_en_i;
  end

  assign ctl_o     = ctl_q;
  assign rd_tail_o = tail_q;

endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import bstrobe_pkg::*;
#(
  parameter int unsigned PH = 2,
  localparam int unsigned CW = $clog2(NUM_STATES * PH)
) (
  input  logic [CW-1:0] idx_i,
  input  cyc_ctl_t      ctl_i,
  input  logic          rd_tail_i,
  output logic          rd_en_o,
  output logic          ale_o,
  output logic          rd_n_o
);

  localparam int unsigned SLOT_A = last_phase_idx(ALE_STATE_A, PH);
  localparam int unsigned SLOT_B = last_phase_idx(ALE_STATE_B, PH);

  logic at_slot_a, at_slot_b;
  logic free_run, pulse_a_ok, pulse_b_ok;
  logic win_a, win_b_head, win_b_tail;

  assign at_slot_a = (int'(idx_i) == SLOT_A);
  assign at_slot_b = (int'(idx_i) == SLOT_B);

  // the latch-off bit only matters while executing internally
  assign free_run   = ctl_i.ext_exec | ~ctl_i.ale_off;
  assign pulse_a_ok = ~ctl_i.xdata & (free_run | ctl_i.table_rd);
  assign pulse_b_ok = free_run | ctl_i.xdata | ctl_i.table_rd;

  assign ale_o = (at_slot_a & pulse_a_ok) | (at_slot_b & pulse_b_ok);

  assign win_a      = in_states(int'(idx_i), RD_A_FIRST, RD_A_LAST, PH);
  assign win_b_head = in_states(int'(idx_i), RD_B_STATE, RD_B_STATE, PH);
  assign win_b_tail = in_states(int'(idx_i), RD_TAIL_ST, RD_TAIL_ST, PH);

  assign rd_en_o = ctl_i.ext_exec & ~ctl_i.xdata;
  assign rd_n_o  = ~((rd_en_o & (win_a | win_b_head)) | (rd_tail_i & win_b_tail));

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bstrobe_pkg::*;
#(
  parameter int unsigned PH = 2
) (
  input  logic osc_clk,
  input  logic rst,
  input  logic ext_exec,
  input  logic xdata_cycle,
  input  logic table_read_cycle,
  input  logic latch_off,
  output logic addr_latch,
  output logic prog_rd_n
);

  localparam int unsigned CYC_LEN = NUM_STATES * PH;
  localparam int unsigned CW      = $clog2(CYC_LEN);

  logic [CW-1:0] cyc_idx;
  logic          cyc_load;
  logic          rd_en;
  logic          rd_tail;
  cyc_ctl_t      ctl_in;
  cyc_ctl_t      ctl_q;

  // named views of the held cycle flags
  logic cur_ext_exec, cur_xdata, cur_table_rd, cur_ale_off;

  assign ctl_in = '{ext_exec: ext_exec, xdata: xdata_cycle,
                    table_rd: table_read_cycle, ale_off: latch_off};

  assign cur_ext_exec = ctl_q.ext_exec;
  assign cur_xdata    = ctl_q.xdata;
  assign cur_table_rd = ctl_q.table_rd;
  assign cur_ale_off  = ctl_q.ale_off;

  mc_phase_counter #(.CYC_LEN(CYC_LEN)) u_cnt (
    .clk   (osc_clk),
    .rst   (rst),
    .idx_o (cyc_idx),
    .load_o(cyc_load)
  );

  cycle_ctl_reg u_ctl (
    .clk      (osc_clk),
    .rst      (rst),
    .load_i   (cyc_load),
    .ctl_i    (ctl_in),
    .rd_en_i  (rd_en),
    .ctl_o    (ctl_q),
    .rd_tail_o(rd_tail)
  );

  strobe_decode #(.PH(PH)) u_dec (
    .idx_i    (cyc_idx),
    .ctl_i    (ctl_q),
    .rd_tail_i(rd_tail),
    .rd_en_o  (rd_en),
    .ale_o    (addr_latch),
    .rd_n_o   (prog_rd_n)
  );

endmodule

// File: rtl/bstrobe_chk.sv
module bstrobe_chk #(
  parameter int unsigned PH = 2,
  localparam int unsigned CW = $clog2(6 * PH)
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cyc_idx,
  input logic          cyc_load,
  input logic          cur_ext_exec,
  input logic          cur_xdata,
  input logic          cur_table_rd,
  input logic          cur_ale_off,
  input logic          rd_tail,
  input logic          ale,
  input logic          rd_n
);

  localparam int unsigned SA = PH - 1;
  localparam int unsigned SB = 4 * PH - 1;

  // R1
  reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (int'(cyc_idx) == 0 && rd_n && !ale));

  // R2
  ale_width_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R2
  ale_slot_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> (int'(cyc_idx) == SA || int'(cyc_idx) == SB));

  // R3
  xdata_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_xdata && int'(cyc_idx) == SA) |-> !ale);

  // R5
  exec_ale_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_ext_exec && !cur_xdata && int'(cyc_idx) == SB) |-> ale);

  // R8
  int_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (!cur_ext_exec && !rd_tail) |-> rd_n);

  // R9
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_load |=> $stable({cur_ext_exec, cur_xdata, cur_table_rd, cur_ale_off}));

endmodule

bind bus_strobe_gen bstrobe_chk #(.PH(PH)) u_chk (
  .clk         (osc_clk),
  .rst         (rst),
  .cyc_idx     (cyc_idx),
  .cyc_load    (cyc_load),
  .cur_ext_exec(cur_ext_exec),
  .cur_xdata   (cur_xdata),
  .cur_table_rd(cur_table_rd),
  .cur_ale_off (cur_ale_off),
  .rd_tail     (rd_tail),
  .ale         (addr_latch),
  .rd_n        (prog_rd_n)
);

// File: tb/bus_strobe_gen_tb.sv
`timescale 1ns/1ps
module bus_strobe_gen_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_exec = 1'b0, xdata_cycle = 1'b0, table_read_cycle = 1'b0, latch_off = 1'b0;
  logic addr_latch, prog_rd_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string phase_tag = "";

  always #2 clk = ~clk;

  bus_strobe_gen u_dut (
    .osc_clk(clk), .rst(rst), .ext_exec(ext_exec), .xdata_cycle(xdata_cycle),
    .table_read_cycle(table_read_cycle), .latch_off(latch_off),
    .addr_latch(addr_latch), .prog_rd_n(prog_rd_n)
  );

  // bench view of the cycle: position and flags taken at each cycle start
  int mt = 0;
  bit m_exec = 0, m_data = 0, m_tbl = 0, m_off = 0, m_tail = 0;

  always @(posedge clk) begin
    if (rst || mt == 11) begin
      m_tail <= rst ? 1'b0 : (m_exec && !m_data);
      mt     <= 0;
      m_exec <= ext_exec;
      m_data <= xdata_cycle;
      m_tbl  <= table_read_cycle;
      m_off  <= latch_off;
    end else begin
      mt <= mt + 1;
    end
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s at pos %0d: actual=%b expected=%b", req, what, mt, act, exp);
    end
  endtask

  // advance one clock and compare both strobes
  task automatic tick();
    bit free, exp_ale, rd_low;
    string ta, tr;
    @(negedge clk);
    free = m_exec || !m_off;
    if (mt % 6 != 1)  exp_ale = 1'b0;
    else if (mt < 6)  exp_ale = !m_data && (free || m_tbl);
    else              exp_ale = free || m_data || m_tbl;
    rd_low = (m_exec && !m_data && (mt / 2 == 2 || mt / 2 == 3 || mt / 2 == 5))
             || (m_tail && mt / 2 == 0);
    if (rst)                    begin ta = "R1"; tr = "R1"; end
    else if (phase_tag != "")   begin ta = phase_tag; tr = phase_tag; end
    else begin
      if (m_data)                    ta = "R3";
      else if (m_off && !m_exec)     ta = "R4";
      else if (m_off && m_exec)      ta = "R5";
      else                           ta = "R2";
      if (m_exec && m_data)          tr = "R7";
      else if (!m_exec)              tr = "R8";
      else                           tr = "R6";
    end
    check(addr_latch, exp_ale, ta, "addr_latch");
    check(prog_rd_n, !rd_low, tr, "prog_rd_n");
  endtask

  task automatic apply(input int code);
    ext_exec         = code[0];
    xdata_cycle      = code[1];
    table_read_cycle = code[2];
    latch_off        = code[3];
  endtask

  initial begin
    repeat (3) tick();            // R1 reset state
    rst = 1'b0;
    // every ordered pair of flag combinations, with shifting alignment
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        apply(a);
        repeat (12 + (b % 5)) tick();
        apply(b);
        repeat (12 + (a % 3)) tick();
      end
    end
    // R9: flags change on every clock; only cycle-start values count
    phase_tag = "R9";
    for (int i = 0; i < 1500; i++) begin
      apply(int'($urandom_range(0, 15)));
      tick();
    end
    phase_tag = "";
    // R1: reset in mid cycle with external execution requested
    apply(1);
    repeat (5) tick();
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    repeat (40) tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule